// File: doc/BRIEF.md
# Effective Memory Type Resolver

This unit decides how one memory access may be cached. It combines three sources of policy. The first is the physical address, looked up in range tables: a fixed table for the lowest megabyte, four variable address windows and a default type. The second is the caching attribute bits taken from each level of the page hierarchy, with the leaf level's bits used as an index into a programmable eight-entry attribute table. The third is a global cache-disable control. Each source can only tighten the caching policy. The most restrictive type wins, so no level can undo a restriction set by another level.

Configuration is loaded through a single write port that is one 64-bit word wide. The address-based and attribute-based results are combinational. A write changes the result from the clock cycle after the write edge. Cache arrays, translation buffers, page walking and coherency sit outside this unit.

Top module: `memTypeResolver`

## Requirements
- R1: The output `effType` is always one of five codes: 0 uncacheable (UC), 1 write-combining (WC), 4 write-through (WT), 5 write-protected (WP), 6 write-back (WB).
- R2: The attribute table is a 64-bit word at write address 0, with entry k in bits [8k+7:8k]. The leaf-level bits select the entry at index {leafPat, lvlPcd[0], lvlPwt[0]}, so the PWT flag is bit 0 of the index.
- R3: After reset, table entries 0 to 3 hold WB, WT, UC, UC, and entries 4 to 7 repeat them. Setting leafPat therefore leaves the result unchanged until the table is rewritten.
- R4: When the address is below 1 MiB, the range type comes from a fixed table of 16 entries, each covering 64 KiB. Entry n is the byte at position n mod 8 of the word at write address 2 + n/8. After reset every entry is WB.
- R5: Variable window i (i from 0 to 3) has a base word at address 4+2i and a mask word at address 5+2i. The base word carries the window type in bits 7:0 and the base in bits 35:12. The mask word carries the mask in bits 35:12 and a valid flag in bit 11. Window i matches an address at or above 1 MiB when it is valid and (address AND mask) equals (base AND mask). After reset every window is invalid.
- R6: When several windows match, the most restrictive type among them is used, so any UC match gives UC and a mix of WT and WB gives WT.
- R7: At or above 1 MiB with no matching window, the default type applies. It is held in bits 7:0 of the word at address 1 and resets to UC.
- R8: The effective type is the most restrictive of the range type, the attribute-table type and the upper-level cap, using the order UC < WC < WT < WP < WB.
- R9: A set PWT bit at any non-leaf level caps the result at WT. A set PCD bit at any non-leaf level forces UC.
- R10: Any stored code outside the five valid codes, in any table, acts as UC.
- R11: While `globalCd` is high the output is UC, whatever the tables hold.
- R12: A write takes effect from the cycle after the clock edge at which `wrEn` is high. Writes to addresses 12 to 15 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Configuration write strobe |
| wrAddr | input | 4 | Configuration word address |
| wrData | input | 64 | Configuration word data |
| physAddr | input | 36 | Physical address of the access |
| lvlPwt | input | 2 | Write-through bit per paging level, index 0 = leaf |
| lvlPcd | input | 2 | Cache-disable bit per paging level, index 0 = leaf |
| leafPat | input | 1 | Attribute-extension bit of the leaf entry |
| globalCd | input | 1 | Global cache disable |
| effType | output | 8 | Effective memory type code |

## Verification
Some properties are checked by assertions on every clock:
- the output code is always legal;
- global disable and upper-level cache-disable force UC;
- upper-level write-through keeps the result at or below WT;
- the output stays steady when neither the inputs nor the configuration change.

Other behaviour can only be shown by the bench's scenarios, which compare every cycle against a behavioural model:
- the attribute-table indexing and its mirrored reset contents;
- fixed-table byte selection;
- window matching and overlap resolution;
- the default type fallback;
- reserved codes;
- ignored write addresses.

// File: rtl/memTypePkg.sv
package memTypePkg;

  localparam int VAR_CNT     = 4;
  localparam int FIX_WORDS   = 2;
  localparam int TYPE_W      = 8;
  localparam int ADDR_DFL    = 1;
  localparam int ADDR_PAT    = 0;
  localparam int ADDR_FIX0   = 2;
  localparam int ADDR_VAR0   = 4;

  localparam logic [TYPE_W-1:0] MT_UC = 8'd0;
  localparam logic [TYPE_W-1:0] MT_WC = 8'd1;
  localparam logic [TYPE_W-1:0] MT_WT = 8'd4;
  localparam logic [TYPE_W-1:0] MT_WP = 8'd5;
  localparam logic [TYPE_W-1:0] MT_WB = 8'd6;

  // strength rank: 0 is the most restrictive
  typedef logic [2:0] rank_t;

  typedef struct packed {
    logic                 patWe;
    logic                 dflWe;
    logic [FIX_WORDS-1:0] fixWe;
    logic [VAR_CNT-1:0]   baseWe;
    logic [VAR_CNT-1:0]   maskWe;
  } cfgStrobe_t;

  function automatic rank_t typeRank(input logic [TYPE_W-1:0] t);
    case (t)
      MT_WC:   return 3'd1;
      MT_WT:   return 3'd2;
      MT_WP:   return 3'd3;
      MT_WB:   return 3'd4;
      default: return 3'd0;   // UC and every reserved code
    endcase
  endfunction

  function automatic logic [TYPE_W-1:0] rankType(input rank_t r);
    case (r)
      3'd1:    return MT_WC;
      3'd2:    return MT_WT;
      3'd3:    return MT_WP;
      3'd4:    return MT_WB;
      default: return MT_UC;
    endcase
  endfunction

  function automatic rank_t minRank(input rank_t a, input rank_t b);
    return (a < b) ? a : b;
  endfunction

endpackage

// File: rtl/mtrCfgCtrl.sv
module mtrCfgCtrl
  import memTypePkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  output cfgStrobe_t        strobes
);

  always_comb begin
    strobes = '0;
    strobes.patWe = wrEn && (wrAddr == ADDR_W'(ADDR_PAT));
    strobes.dflWe = wrEn && (wrAddr == ADDR_W'(ADDR_DFL));
    for (int w = 0; w < FIX_WORDS; w++) begin
      strobes.fixWe[w] = wrEn && (wrAddr == ADDR_W'(ADDR_FIX0 + w));
    end
    for (int v = 0; v < VAR_CNT; v++) begin
      strobes.baseWe[v] = wrEn && (wrAddr == ADDR_W'(ADDR_VAR0 + 2*v));
      strobes.maskWe[v] = wrEn && (wrAddr == ADDR_W'(ADDR_VAR0 + 2*v + 1));
    end
  end

endmodule

// File: rtl/mtrTypeDatapath.sv
module mtrTypeDatapath
  import memTypePkg::*;
#(
  parameter int          PA_W      = 36,
  parameter int          LEVELS    = 2,
  parameter logic [63:0] PAT_RESET = 64'h0000_0406_0000_0406,
  parameter logic [63:0] FIX_RESET = 64'h0606_0606_0606_0606
) (
  input  logic              clk,
  input  logic              rstN,
  input  cfgStrobe_t        strobes,
  input  logic [63:0]       wrData,
  input  logic [PA_W-1:0]   physAddr,
  input  logic [LEVELS-1:0] lvlPwt,
  input  logic [LEVELS-1:0] lvlPcd,
  input  logic              leafPat,
  input  logic              globalCd,
  output logic [TYPE_W-1:0] effType
);

  localparam int PG_LSB  = 12;
  localparam int MEG_LSB = 20;
  localparam int FRAME_W = PA_W - PG_LSB;

  logic [63:0]        patReg;
  logic [TYPE_W-1:0]  dflReg;
  logic [63:0]        fixReg   [FIX_WORDS];
  logic [FRAME_W-1:0] varBase  [VAR_CNT];
  logic [FRAME_W-1:0] varMask  [VAR_CNT];
  logic [TYPE_W-1:0]  varType  [VAR_CNT];
  logic [VAR_CNT-1:0] varValid;

  // configuration storage
  always_ff @(posedge clk) begin
    if (!rstN) begin
      patReg   <= PAT_RESET;
      dflReg   <= MT_UC;
      varValid <= '0;
      for (int w = 0; w < FIX_WORDS; w++) fixReg[w] <= FIX_RESET;
      for (int v = 0; v < VAR_CNT; v++) begin
        varBase[v] <= '0;
        varMask[v] <= '0;
        varType[v] <= MT_UC;
      end
    end else begin
      if (strobes.patWe) patReg <= wrData;
      if (strobes.dflWe) dflReg <= wrData[TYPE_W-1:0];
      for (int w = 0; w < FIX_WORDS; w++) begin
        if (strobes.fixWe[w]) fixReg[w] <= wrData;
      end
      for (int v = 0; v < VAR_CNT; v++) begin
        if (strobes.baseWe[v]) begin
          varBase[v] <= wrData[PA_W-1:PG_LSB];
          varType[v] <= wrData[TYPE_W-1:0];
        end
        if (strobes.maskWe[v]) begin
          varMask[v]  <= wrData[PA_W-1:PG_LSB];
          varValid[v] <= wrData[11];
        end
      end
    end
  end

  // attribute table lookup from leaf bits
  logic [2:0] patIdx;
  rank_t      patRank;
  always_comb begin
    patIdx  = {leafPat, lvlPcd[0], lvlPwt[0]};
    patRank = typeRank(patReg[{patIdx, 3'b000} +: TYPE_W]);
  end

  // fixed table below 1 MiB
  logic       lowMeg;
  logic [3:0] fixSel;
  rank_t      fixRank;
  always_comb begin
    lowMeg  = (physAddr[PA_W-1:MEG_LSB] == '0);
    fixSel  = physAddr[MEG_LSB-1:16];
    fixRank = typeRank(fixReg[fixSel[3]][{fixSel[2:0], 3'b000} +: TYPE_W]);
  end

  // variable windows
  logic [VAR_CNT-1:0] varHit;
  rank_t              varRankEach [VAR_CNT];
  for (genvar gv = 0; gv < VAR_CNT; gv++) begin : g_win
    assign varHit[gv] = varValid[gv] &&
      ((physAddr[PA_W-1:PG_LSB] & varMask[gv]) == (varBase[gv] & varMask[gv]));
    assign varRankEach[gv] = typeRank(varType[gv]);
  end

  rank_t varRankMin;
  always_comb begin
    varRankMin = 3'd7;
    for (int v = 0; v < VAR_CNT; v++) begin
      if (varHit[v]) varRankMin = minRank(varRankMin, varRankEach[v]);
    end
  end

  // upper-level restrictions
  logic  upPwt, upPcd;
  rank_t capRank, rangeRank, finalRank;
  always_comb begin
    upPwt     = |lvlPwt[LEVELS-1:1];
    upPcd     = |lvlPcd[LEVELS-1:1];
    capRank   = upPcd ? 3'd0 : (upPwt ? 3'd2 : 3'd4);
    rangeRank = lowMeg ? fixRank : ((|varHit) ? varRankMin : typeRank(dflReg));
    finalRank = globalCd ? 3'd0 : minRank(minRank(rangeRank, patRank), capRank);
    effType   = rankType(finalRank);
  end

endmodule

// File: rtl/memTypeResolver.sv
module memTypeResolver
  import memTypePkg::*;
#(
  parameter int PA_W   = 36,
  parameter int LEVELS = 2,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [63:0]       wrData,
  input  logic [PA_W-1:0]   physAddr,
  input  logic [LEVELS-1:0] lvlPwt,
  input  logic [LEVELS-1:0] lvlPcd,
  input  logic              leafPat,
  input  logic              globalCd,
  output logic [7:0]        effType
);

  cfgStrobe_t strobes;

  mtrCfgCtrl #(.ADDR_W(ADDR_W)) ctrl (
    .wrEn    (wrEn),
    .wrAddr  (wrAddr),
    .strobes (strobes)
  );

  mtrTypeDatapath #(.PA_W(PA_W), .LEVELS(LEVELS)) dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .wrData   (wrData),
    .physAddr (physAddr),
    .lvlPwt   (lvlPwt),
    .lvlPcd   (lvlPcd),
    .leafPat  (leafPat),
    .globalCd (globalCd),
    .effType  (effType)
  );

endmodule

// File: rtl/memTypeResolverChk.sv
module memTypeResolverChk #(
  parameter int PA_W   = 36,
  parameter int LEVELS = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic [PA_W-1:0]   physAddr,
  input logic [LEVELS-1:0] lvlPwt,
  input logic [LEVELS-1:0] lvlPcd,
  input logic              leafPat,
  input logic              globalCd,
  input logic [7:0]        effType
);

  a_r1_legal_code: assert property (@(posedge clk) disable iff (!rstN)
    (effType == 8'd0 || effType == 8'd1 || effType == 8'd4 ||
     effType == 8'd5 || effType == 8'd6));

  a_r11_global_disable: assert property (@(posedge clk) disable iff (!rstN)
    globalCd |-> (effType == 8'd0));

  a_r9_upper_pcd_uc: assert property (@(posedge clk) disable iff (!rstN)
    (|lvlPcd[LEVELS-1:1]) |-> (effType == 8'd0));

  a_r9_upper_pwt_cap: assert property (@(posedge clk) disable iff (!rstN)
    (|lvlPwt[LEVELS-1:1]) |-> (effType == 8'd0 || effType == 8'd1 || effType == 8'd4));

  a_r12_steady_without_change: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && !$past(wrEn) && $stable(physAddr) && $stable(lvlPwt) &&
     $stable(lvlPcd) && $stable(leafPat) && $stable(globalCd)) |-> $stable(effType));

endmodule

bind memTypeResolver memTypeResolverChk #(.PA_W(PA_W), .LEVELS(LEVELS)) chk (.*);

// File: tb/memTypeResolver_test.sv
`timescale 1ns/1ps
module memTypeResolver_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [3:0]  wrAddr = '0;
  logic [63:0] wrData = '0;
  logic [35:0] physAddr = '0;
  logic [1:0]  lvlPwt = '0;
  logic [1:0]  lvlPcd = '0;
  logic        leafPat = 1'b0;
  logic        globalCd = 1'b0;
  logic [7:0]  effType;

  int checks = 0;
  int fails  = 0;
  string curReq = "R3";

  // behavioural model state
  logic [63:0] mPat, mFix0, mFix1, mDfl;
  logic [63:0] mBase [4];
  logic [63:0] mMask [4];

  always #2.5 clk = ~clk;

  memTypeResolver uut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .physAddr(physAddr), .lvlPwt(lvlPwt), .lvlPcd(lvlPcd), .leafPat(leafPat),
    .globalCd(globalCd), .effType(effType)
  );

  function automatic int strength(input logic [7:0] c);
    if (c == 8'd1) return 1;
    if (c == 8'd4) return 2;
    if (c == 8'd5) return 3;
    if (c == 8'd6) return 4;
    return 0;
  endfunction

  function automatic logic [7:0] fromStrength(input int s);
    logic [7:0] codes [5] = '{8'd0, 8'd1, 8'd4, 8'd5, 8'd6};
    return codes[s];
  endfunction

  task automatic modelReset();
    mPat  = 64'h0000_0406_0000_0406;
    mFix0 = 64'h0606_0606_0606_0606;
    mFix1 = 64'h0606_0606_0606_0606;
    mDfl  = 64'h0;
    for (int i = 0; i < 4; i++) begin mBase[i] = '0; mMask[i] = '0; end
  endtask

  function automatic logic [7:0] expected();
    int best, rng, pat, cap, n;
    logic [35:0] m;
    logic [63:0] fw;
    if (globalCd) return 8'd0;
    if (physAddr < 36'h10_0000) begin
      n  = int'(physAddr[19:16]);
      fw = (n < 8) ? mFix0 : mFix1;
      rng = strength(fw[(n % 8)*8 +: 8]);
    end else begin
      best = 99;
      for (int i = 0; i < 4; i++) begin
        m = {mMask[i][35:12], 12'h000};
        if (mMask[i][11] && ((physAddr & m) == (mBase[i][35:0] & m))) begin
          if (strength(mBase[i][7:0]) < best) best = strength(mBase[i][7:0]);
        end
      end
      rng = (best == 99) ? strength(mDfl[7:0]) : best;
    end
    n   = 4*int'(leafPat) + 2*int'(lvlPcd[0]) + int'(lvlPwt[0]);
    pat = strength(mPat[n*8 +: 8]);
    cap = lvlPcd[1] ? 0 : (lvlPwt[1] ? 2 : 4);
    best = rng;
    if (pat < best) best = pat;
    if (cap < best) best = cap;
    return fromStrength(best);
  endfunction

  task automatic tick();
    @(posedge clk);
    if (!rstN) modelReset();
    else if (wrEn) begin
      case (wrAddr)
        4'd0: mPat = wrData;
        4'd1: mDfl = wrData;
        4'd2: mFix0 = wrData;
        4'd3: mFix1 = wrData;
        4'd4, 4'd6, 4'd8, 4'd10: mBase[(int'(wrAddr) - 4) / 2] = wrData;
        4'd5, 4'd7, 4'd9, 4'd11: mMask[(int'(wrAddr) - 5) / 2] = wrData;
        default: ;
      endcase
    end
    @(negedge clk);
    if (rstN) begin
      checks++;
      if (effType !== expected()) begin
        fails++;
        $display("FAIL %s: effType=%0d expected=%0d addr=%h pwt=%b pcd=%b pat=%b cd=%b",
                 curReq, effType, expected(), physAddr, lvlPwt, lvlPcd, leafPat, globalCd);
      end
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [63:0] d);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    tick();
    wrEn = 1'b0;
  endtask

  task automatic look(input logic [35:0] a, input logic [1:0] pwt, input logic [1:0] pcd,
                      input logic pat, input logic cd);
    physAddr = a; lvlPwt = pwt; lvlPcd = pcd; leafPat = pat; globalCd = cd;
    tick();
  endtask

  initial begin
    #100000;
    fails++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    modelReset();
    repeat (3) tick();
    rstN = 1'b1;

    // R3: reset state, mirrored table halves, R2 indexing
    curReq = "R3";
    look(36'h0, 2'b00, 2'b00, 1'b0, 1'b0);
    for (int idx = 0; idx < 8; idx++) begin
      look(36'h0, {1'b0, idx[0]}, {1'b0, idx[1]}, idx[2], 1'b0);
    end

    // R7: default type at/above 1 MiB
    curReq = "R7";
    look(36'h10_0000, 2'b00, 2'b00, 1'b0, 1'b0);
    wr(4'd1, 64'h6);
    look(36'h8_0000_0000, 2'b00, 2'b00, 1'b0, 1'b0);

    // R2 and R10: new table including a reserved code in entry 5
    curReq = "R2";
    wr(4'd0, 64'h0406_0205_0100_0406);
    for (int idx = 0; idx < 8; idx++) begin
      curReq = (idx == 5) ? "R10" : "R2";
      look(36'h20_0000, {1'b0, idx[0]}, {1'b0, idx[1]}, idx[2], 1'b0);
    end

    // R4: fixed table byte selection
    curReq = "R4";
    wr(4'd2, 64'h0606_0606_0406_0606);
    wr(4'd3, 64'h0506_0606_0606_0103);
    look(36'h3_0000, 2'b00, 2'b00, 1'b0, 1'b0);
    look(36'h7_0000, 2'b00, 2'b00, 1'b0, 1'b0);
    look(36'hF_FFFF, 2'b00, 2'b00, 1'b0, 1'b0);
    look(36'h9_1234, 2'b00, 2'b00, 1'b0, 1'b0);
    curReq = "R10";
    look(36'h8_0000, 2'b00, 2'b00, 1'b0, 1'b0);

    // R5: variable window, invalid until mask valid bit
    curReq = "R5";
    wr(4'd4, 64'h0000_0000_0010_0001);
    look(36'h18_0000, 2'b00, 2'b00, 1'b0, 1'b0);
    wr(4'd5, 64'h0000_000F_FFF0_0800);
    look(36'h18_0000, 2'b00, 2'b00, 1'b0, 1'b0);
    look(36'h20_0000, 2'b00, 2'b00, 1'b0, 1'b0);
    look(36'h8_0010_0000, 2'b00, 2'b00, 1'b0, 1'b0);

    // R6: overlap resolution
    curReq = "R6";
    wr(4'd6, 64'h0000_0000_0010_0000);
    wr(4'd7, 64'h0000_000F_FFFF_0800);
    look(36'h10_8000, 2'b00, 2'b00, 1'b0, 1'b0);
    wr(4'd4, 64'h0000_0000_0010_0006);
    wr(4'd6, 64'h0000_0000_0010_0004);
    look(36'h10_8000, 2'b00, 2'b00, 1'b0, 1'b0);
    look(36'h18_0000, 2'b00, 2'b00, 1'b0, 1'b0);

    // R8 and R9: combination and upper-level caps
    curReq = "R8";
    look(36'h18_0000, 2'b00, 2'b00, 1'b1, 1'b0);
    look(36'h10_8000, 2'b00, 2'b00, 1'b1, 1'b0);
    curReq = "R9";
    look(36'h18_0000, 2'b10, 2'b00, 1'b0, 1'b0);
    look(36'h18_0000, 2'b10, 2'b00, 1'b1, 1'b0);
    look(36'h18_0000, 2'b00, 2'b10, 1'b0, 1'b0);
    look(36'h0, 2'b11, 2'b00, 1'b0, 1'b0);

    // R11: global disable
    curReq = "R11";
    look(36'h18_0000, 2'b00, 2'b00, 1'b0, 1'b1);
    look(36'h0, 2'b00, 2'b00, 1'b0, 1'b1);

    // R12: unmapped addresses leave all state untouched
    curReq = "R12";
    for (int a = 12; a < 16; a++) wr(4'(a), 64'h0);
    look(36'h18_0000, 2'b00, 2'b00, 1'b0, 1'b0);
    look(36'h10_8000, 2'b00, 2'b00, 1'b0, 1'b0);
    look(36'h3_0000, 2'b00, 2'b00, 1'b0, 1'b0);
    look(36'h40_0000, 2'b00, 2'b00, 1'b0, 1'b0);
    look(36'h20_0000, 2'b00, 2'b00, 1'b1, 1'b0);
    // R1: sweep a few addresses once more
    curReq = "R1";
    for (int k = 0; k < 16; k++) look(36'(k) << 18, 2'(k), 2'b00, k[2], 1'b0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule